// File: doc/BRIEF.md
# Binary/Gray Mode Counter

A synchronous up counter, three bits wide by default, whose register steps through one of two cyclic orders. A mode input picks the order. With mode low, the count follows plain binary order. With mode high, it follows the reflected Gray order, in which neighbouring codes differ in a single bit. The mode is read on every rising clock edge. The successor is always taken from the code the register holds right now, so a mode change mid-count continues from that code. Nothing is converted between the two orders.

The register is the output. Each of the eight codes is one state, and each state has two outgoing arcs, one for each mode. A synchronous, active-high reset returns the register to all zeros. The block suits control paths that sometimes need a single-bit-change sequence and sometimes a plain binary one.

Top module: `bgc_mode_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the count becomes 000 on that edge, whatever `mode` is. After reset is released, the count reads 000.
- R2: With `mode` = 0 (binary order), each rising edge advances the count along 000, 001, 010, 011, 100, 101, 110, 111 and back to 000.
- R3: With `mode` = 1 (Gray order), each rising edge advances the count along 000, 001, 011, 010, 110, 111, 101, 100 and back to 000.
- R4: Every step taken with `mode` = 1 changes exactly one bit of the count.
- R5: The successor depends only on the present code and on the `mode` value sampled at the same edge. For example, 010 moves to 110 when `mode` = 1 and to 011 when `mode` = 0, and 110 moves to 111 in either mode.
- R6: Each order wraps to 000. Binary wraps from 111, and Gray wraps from 100.
- R7: `count` is a registered output. A change on `mode` between edges leaves `count` unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 1 | 0 selects binary order, 1 selects Gray order |
| count | output | WIDTH (3) | Current code, equal to the state register |

## Verification
The step assertions assume that `mode` and `rst` are settled at each rising edge. They also assume one reset edge has come before any step is checked. The bench drives every input on the falling edge, so the inputs stay settled at the rising edge. It starts each sequence with a reset pulse. The bench reaches every code, then applies each mode to it and compares the result with a lookup table. A long run then toggles `mode` at random, and the bench follows each step with the same table.

// File: rtl/bgc_pkg.sv
package bgc_pkg;
  typedef enum logic {
    MODE_BIN  = 1'b0,
    MODE_GRAY = 1'b1
  } bgc_mode_e;
endpackage

// File: rtl/bgc_gray_to_bin.sv
module bgc_gray_to_bin #(
  parameter int WIDTH = 3
) (
  input  logic [WIDTH-1:0] gray_in,
  output logic [WIDTH-1:0] bin_out
);
  localparam int MSB = WIDTH - 1;

  assign bin_out[MSB] = gray_in[MSB];

  genvar i;
  generate
    for (i = MSB - 1; i >= 0; i--) begin : g_fold
      assign bin_out[i] = bin_out[i+1] ^ gray_in[i];
    end
  endgenerate
endmodule

// File: rtl/bgc_succ.sv
module bgc_succ
  import bgc_pkg::*;
#(
  parameter int WIDTH = 3
) (
  input  logic [WIDTH-1:0] cur,
  input  bgc_mode_e        sel,
  output logic [WIDTH-1:0] nxt
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] bin_next;
  logic [WIDTH-1:0] gray_rank;
  logic [WIDTH-1:0] gray_rank_next;
  logic [WIDTH-1:0] gray_next;

  // binary arc: plain increment, wraps naturally
  assign bin_next = cur + ONE;

  // Gray arc: rank the code, bump the rank, re-encode
  bgc_gray_to_bin #(.WIDTH(WIDTH)) i_rank (
    .gray_in (cur),
    .bin_out (gray_rank)
  );
  assign gray_rank_next = gray_rank + ONE;
  assign gray_next      = gray_rank_next ^ (gray_rank_next >> 1);

  always_comb begin
    unique case (sel)
      MODE_GRAY: nxt = gray_next;
      default:   nxt = bin_next;
    endcase
  end
endmodule

// File: rtl/bgc_count_reg.sv
module bgc_count_reg #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_gray,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] TOP_GRAY = WIDTH'(1) << (WIDTH - 1);
  localparam logic [WIDTH-1:0] ALL_ONES = '1;

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

  // marks that a reset edge has been seen, so step checks have history
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b1;
  end

  // R1: reset edge leaves zero
  a_r1_reset_zero: assert property (@(posedge clk)
    $past(rst) |-> (q == '0));

  // R2: binary step differs by one
  a_r2_bin_step: assert property (@(posedge clk) disable iff (rst)
    (armed === 1'b1 && !sel_gray) |=> (q - $past(q) == WIDTH'(1)));

  // R4: Gray step flips exactly one bit
  a_r4_gray_one_bit: assert property (@(posedge clk) disable iff (rst)
    (armed === 1'b1 && sel_gray) |=> ($countones(q ^ $past(q)) == 1));

  // R6: Gray order wraps from its last code
  a_r6_gray_wrap: assert property (@(posedge clk) disable iff (rst)
    (armed === 1'b1 && sel_gray && q == TOP_GRAY) |=> (q == '0));

  // R6: binary order wraps from all ones
  a_r6_bin_wrap: assert property (@(posedge clk) disable iff (rst)
    (armed === 1'b1 && !sel_gray && q == ALL_ONES) |=> (q == '0));
endmodule

// File: rtl/bgc_mode_counter.sv
module bgc_mode_counter
  import bgc_pkg::*;
#(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode,
  output logic [WIDTH-1:0] count
);
  logic [WIDTH-1:0] nxt;
  bgc_mode_e        sel;

  assign sel = bgc_mode_e'(mode);

  bgc_succ #(.WIDTH(WIDTH)) i_succ (
    .cur (count),
    .sel (sel),
    .nxt (nxt)
  );

  bgc_count_reg #(.WIDTH(WIDTH)) i_reg (
    .clk      (clk),
    .rst      (rst),
    .sel_gray (mode),
    .d        (nxt),
    .q        (count)
  );
endmodule

// File: tb/test_bgc_mode_counter.sv
module test_bgc_mode_counter;
  localparam int W = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b0;
  logic         mode = 1'b0;
  logic [W-1:0] count;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  bgc_mode_counter #(.WIDTH(W)) i_bgc_mode_counter (
    .clk   (clk),
    .rst   (rst),
    .mode  (mode),
    .count (count)
  );

  // {present code, mode, expected successor}
  localparam logic [6:0] VEC [16] = '{
    7'b000_0_001, 7'b000_1_001,
    7'b001_0_010, 7'b001_1_011,
    7'b010_0_011, 7'b010_1_110,
    7'b011_0_100, 7'b011_1_010,
    7'b100_0_101, 7'b100_1_000,
    7'b101_0_110, 7'b101_1_100,
    7'b110_0_111, 7'b110_1_111,
    7'b111_0_000, 7'b111_1_101
  };

  function automatic logic [W-1:0] model(input logic [W-1:0] s, input logic m);
    logic [6:0] e;
    e = VEC[{s, m}];
    return e[2:0];
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: count=%b expected=%b", req, act, exp);
    end
  endtask

  // one rising edge; inputs were set on the prior falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step();
    rst = 1'b0;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: count=%b expected=done", count);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] exp;
    @(negedge clk);
    mode = 1'b1;
    do_reset();
    chk("R1 reset state", count, 3'b000);

    // table walk: reach each code in binary, then apply the mode under test
    for (int i = 0; i < 16; i++) begin
      do_reset();
      mode = 1'b0;
      for (int k = 0; k < int'(VEC[i][6:4]); k++) step();
      mode = VEC[i][3];
      step();
      chk(VEC[i][3] ? "R3/R5 gray arc" : "R2/R5 binary arc", count, VEC[i][2:0]);
    end

    // full binary lap with wrap (R2, R6)
    do_reset();
    mode = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      step();
      chk("R2 binary lap", count, W'(k));
    end
    chk("R6 binary wrap", count, 3'b000);

    // full Gray lap with wrap (R3, R6)
    do_reset();
    mode = 1'b1;
    exp = '0;
    for (int k = 0; k < 8; k++) begin
      exp = model(exp, 1'b1);
      step();
      chk("R3 gray lap", count, exp);
    end
    chk("R6 gray wrap", count, 3'b000);

    // mid-count switch continues from the current code (R5)
    do_reset();
    mode = 1'b0;
    step(); step();
    chk("R5 reach 010", count, 3'b010);
    mode = 1'b1;
    step();
    chk("R5 010 gray->110", count, 3'b110);
    mode = 1'b0;
    step();
    chk("R5 110 bin->111", count, 3'b111);

    // reset wins over Gray mode mid-count (R1)
    mode = 1'b1;
    step();
    chk("R1 pre-reset 101", count, 3'b101);
    rst = 1'b1;
    step();
    chk("R1 reset dominates", count, 3'b000);
    rst = 1'b0;

    // mode change between edges does not move count (R7)
    step();
    chk("R7 before", count, 3'b001);
    @(posedge clk);
    #3;
    exp = count;
    mode = ~mode;
    #4;
    chk("R7 held after mode change", count, exp);
    @(negedge clk);
    chk("R7 held to next edge", count, exp);

    // random mode toggles tracked by the table model (R5)
    do_reset();
    exp = '0;
    for (int k = 0; k < 300; k++) begin
      mode = 1'($urandom_range(0, 1));
      exp = model(exp, mode);
      step();
      chk("R5 random toggles", count, exp);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule